// File: doc/BRIEF.md
# Dual Flag Set Arithmetic Logic Unit

This block is the 16-bit execution unit of a small microcontroller core. Each clock cycle it takes two register operands and a 4-bit operation code, and it produces a result on a combinational path. It keeps two separate condition registers. Each register holds carry, zero, sign and overflow.

The arithmetic register records the effect of add, subtract, logic and shift operations. Because it keeps the carry, multiword add and subtract chains work, and so do rotates through carry. The compare register changes only on the register-to-register compare and test operations, so the program can hold a compare outcome while arithmetic runs between the compare and the branch that uses it.

Each operation class writes a fixed subset of flags and leaves the others as they were. One operation code forms an address (a plus b) and changes no flag, which is how load and store addressing is done. There is no multiplier. Shifts move by one bit only.

The block has no state machine. Its only state is the two flag registers. Each flag register loads under a per-flag write mask that is decoded from the operation code in the same cycle.

Top module: `dual_flag_alu`

## Requirements
- R1: While rst_n is low, and after it is released, both flag outputs read 0 until an operation writes them. Flag vectors are packed as bit 3 carry, bit 2 zero, bit 1 sign, bit 0 overflow. Flag registers update on the rising clock edge. result is combinational.
- R2: ADD (op 0) gives a+b and SUB (op 2) gives a-b, both modulo 2^16. Both operations write all four arithmetic flags. Carry is the carry out for add and NOT borrow for subtract. Zero is set when the result is 0. Sign is result bit 15. Overflow is the carry into bit 15 XOR the carry out of bit 15.
- R3: ADC (op 1) gives a+b+C and SBC (op 3) gives a-b-(1-C), where C is the current arithmetic carry. Their flags follow R2, so multiword chains are exact.
- R4: AND (4), OR (5), XOR (6), NOT (7, result ~a) and MOV (8, result b) write only zero and sign in the arithmetic set. Arithmetic carry and overflow keep their values.
- R5: SHL (9) and SHR (10) shift a by one bit and fill the vacated bit with 0. The outgoing bit goes to arithmetic carry and zero is updated. Arithmetic sign and overflow keep their values.
- R6: RLC (11) gives {a[14:0],C} and RRC (12) gives {C,a[15:1]}, where C is the old arithmetic carry. The outgoing bit becomes the new carry and zero is updated. Sign and overflow keep their values.
- R7: CMP (13) computes a-b and writes all four flags to the compare set, with the same rules as SUB. TST (14) computes a&b and writes compare zero and sign only. Neither operation changes the arithmetic set.
- R8: The compare flag set changes only on CMP and TST.
- R9: ADDR (15) gives a+b and changes no flag in either set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code, sampled every cycle |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| result | output | 16 | Combinational operation result |
| arith_flags | output | 4 | Arithmetic flag set {C,Z,S,V} |
| cmp_flags | output | 4 | Compare flag set {C,Z,S,V} |

## Verification
The assertions check on every cycle that each operation class leaves its protected flags untouched. Compare and test must not move the arithmetic set. Logic operations must keep carry and overflow. Shifts must keep sign and overflow. ADDR must keep both sets. The compare set must hold on every other operation. After an add, zero and sign must match the result.

Only the bench scenarios can show that the values are correct. Those cases are:
- overflow at the signed boundaries;
- carry and borrow propagating through multiword ADC/SBC chains;
- a bit rotated out through carry and back in;
- a compare result surviving intervening arithmetic.

The bench checks these against a behavioural model on every cycle, with both directed and random operations.

// File: rtl/dfalu_pkg.sv
package dfalu_pkg;

    localparam int NUM_FLAGS = 4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOT  = 4'd7,
        OP_MOV  = 4'd8,
        OP_SHL  = 4'd9,
        OP_SHR  = 4'd10,
        OP_RLC  = 4'd11,
        OP_RRC  = 4'd12,
        OP_CMP  = 4'd13,
        OP_TST  = 4'd14,
        OP_ADDR = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
    } flags_t;

    // write masks, same packing as flags_t
    localparam logic [NUM_FLAGS-1:0] WE_ALL  = 4'b1111;
    localparam logic [NUM_FLAGS-1:0] WE_ZS   = 4'b0110;
    localparam logic [NUM_FLAGS-1:0] WE_CZ   = 4'b1100;
    localparam logic [NUM_FLAGS-1:0] WE_NONE = 4'b0000;

endpackage

// File: rtl/dfalu_shift.sv
module dfalu_shift #(
    parameter int W = 16
) (
    input  logic [1:0]   mode,   // 0 left, 1 right, 2 rotate-left via C, 3 rotate-right via C
    input  logic [W-1:0] din,
    input  logic         cin,
    output logic [W-1:0] dout,
    output logic         cout
);

    logic fill;

    always_comb begin
        fill = mode[1] ? cin : 1'b0;
        if (mode[0]) begin
            dout = {fill, din[W-1:1]};
            cout = din[0];
        end else begin
            dout = {din[W-2:0], fill};
            cout = din[W-1];
        end
    end

endmodule

// File: rtl/dfalu_core.sv
module dfalu_core
    import dfalu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e                op,
    input  logic [W-1:0]           a,
    input  logic [W-1:0]           b,
    input  logic                   carry_in,
    output logic [W-1:0]           result,
    output flags_t                 nf,
    output logic [NUM_FLAGS-1:0]   arith_we,
    output logic [NUM_FLAGS-1:0]   cmp_we
);

    logic [W-1:0] bx;
    logic         cin;
    logic [W:0]   sum_full;
    logic [W-1:0] sum_low;
    logic         add_ovf;
    logic [1:0]   sh_mode;
    logic [W-1:0] sh_out;
    logic         sh_cout;

    // operand conditioning for the shared adder
    always_comb begin
        bx  = b;
        cin = 1'b0;
        case (op)
            OP_ADC:         cin = carry_in;
            OP_SUB, OP_CMP: begin bx = ~b; cin = 1'b1; end
            OP_SBC:         begin bx = ~b; cin = carry_in; end
            default:        ;
        endcase
        sum_full = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cin};
        sum_low  = {1'b0, a[W-2:0]} + {1'b0, bx[W-2:0]} + {{(W-1){1'b0}}, cin};
        add_ovf  = sum_low[W-1] ^ sum_full[W];
    end

    assign sh_mode = op[3:0] - 4'd9;

    dfalu_shift #(.W(W)) u_shift (
        .mode (sh_mode),
        .din  (a),
        .cin  (carry_in),
        .dout (sh_out),
        .cout (sh_cout)
    );

    always_comb begin
        result   = sum_full[W-1:0];
        nf.c     = sum_full[W];
        nf.v     = add_ovf;
        arith_we = WE_NONE;
        cmp_we   = WE_NONE;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: arith_we = WE_ALL;
            OP_AND:  begin result = a & b; arith_we = WE_ZS; end
            OP_OR:   begin result = a | b; arith_we = WE_ZS; end
            OP_XOR:  begin result = a ^ b; arith_we = WE_ZS; end
            OP_NOT:  begin result = ~a;    arith_we = WE_ZS; end
            OP_MOV:  begin result = b;     arith_we = WE_ZS; end
            OP_SHL, OP_SHR, OP_RLC, OP_RRC: begin
                result   = sh_out;
                nf.c     = sh_cout;
                arith_we = WE_CZ;
            end
            OP_CMP:  cmp_we = WE_ALL;
            OP_TST:  begin result = a & b; cmp_we = WE_ZS; end
            default: ;  // OP_ADDR: a+b, no flag writes
        endcase
        nf.z = (result == '0);
        nf.s = result[W-1];
    end

endmodule

// File: rtl/dfalu_flag_bank.sv
module dfalu_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] we,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (we[i])
                q[i] <= d[i];
        end
    end

endmodule

// File: rtl/dual_flag_alu.sv
module dual_flag_alu
    import dfalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [3:0]     op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   result,
    output logic [3:0]     arith_flags,
    output logic [3:0]     cmp_flags
);

    alu_op_e              op_e;
    flags_t               nf;
    flags_t               arith_q;
    logic [NUM_FLAGS-1:0] arith_we;
    logic [NUM_FLAGS-1:0] cmp_we;

    assign op_e = alu_op_e'(op);

    dfalu_core #(.W(W)) u_core (
        .op       (op_e),
        .a        (a),
        .b        (b),
        .carry_in (arith_q.c),
        .result   (result),
        .nf       (nf),
        .arith_we (arith_we),
        .cmp_we   (cmp_we)
    );

    dfalu_flag_bank #(.N(NUM_FLAGS)) u_arith_bank (
        .clk (clk), .rst_n (rst_n), .we (arith_we), .d (nf), .q (arith_q)
    );

    dfalu_flag_bank #(.N(NUM_FLAGS)) u_cmp_bank (
        .clk (clk), .rst_n (rst_n), .we (cmp_we), .d (nf), .q (cmp_flags)
    );

    assign arith_flags = arith_q;

    // R7
    cmp_keeps_arith_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_CMP || op_e == OP_TST) |=> $stable(arith_flags));

    // R8
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_e == OP_CMP || op_e == OP_TST) |=> $stable(cmp_flags));

    // R4
    logic_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_MOV})
        |=> (arith_flags[3] == $past(arith_flags[3]) && arith_flags[0] == $past(arith_flags[0])));

    // R5
    shift_sv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e inside {OP_SHL, OP_SHR, OP_RLC, OP_RRC})
        |=> (arith_flags[1] == $past(arith_flags[1]) && arith_flags[0] == $past(arith_flags[0])));

    // R9
    addr_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_ADDR) |=> ($stable(arith_flags) && $stable(cmp_flags)));

    // R2
    add_zs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_ADD)
        |=> (arith_flags[2] == ($past(result) == '0) && arith_flags[1] == $past(result[W-1])));

endmodule

// File: tb/dual_flag_alu_test.sv
module dual_flag_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd15;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic [15:0] result;
    logic [3:0]  arith_flags;
    logic [3:0]  cmp_flags;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [3:0] m_ar = '0;
    logic [3:0] m_cp = '0;

    always #10 clk = ~clk;

    dual_flag_alu uut (
        .clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b),
        .result(result), .arith_flags(arith_flags), .cmp_flags(cmp_flags)
    );

    function automatic string tag_of(input int o);
        case (o)
            0, 2:                 return "R2";
            1, 3:                 return "R3";
            4, 5, 6, 7, 8:        return "R4";
            9, 10:                return "R5";
            11, 12:               return "R6";
            13, 14:               return "R7";
            default:              return "R9";
        endcase
    endfunction

    task automatic check(input string tg, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", tg, what, got, exp);
        end
    endtask

    // behavioural model of one operation
    task automatic model(input int o, input int ua, input int ub,
                         output int r, output logic [3:0] nar, output logic [3:0] ncp);
        int c, sa, sb, sv, s, bw;
        bit fc, fv;
        c  = m_ar[3];
        sa = (ua >= 32768) ? ua - 65536 : ua;
        sb = (ub >= 32768) ? ub - 65536 : ub;
        nar = m_ar;
        ncp = m_cp;
        fc = 0; fv = 0; r = 0;
        case (o)
            0, 1, 15: begin
                bw = (o == 1) ? c : 0;
                s  = ua + ub + bw;
                sv = sa + sb + bw;
                r  = s & 16'hFFFF;
                fc = (s > 65535);
                fv = (sv > 32767) || (sv < -32768);
            end
            2, 3, 13: begin
                bw = (o == 3) ? 1 - c : 0;
                s  = ua - ub - bw;
                sv = sa - sb - bw;
                r  = s & 16'hFFFF;
                fc = (s >= 0);
                fv = (sv > 32767) || (sv < -32768);
            end
            4, 14: r = ua & ub;
            5:  r = ua | ub;
            6:  r = ua ^ ub;
            7:  r = (~ua) & 16'hFFFF;
            8:  r = ub;
            9:  begin r = (ua * 2) & 16'hFFFF;            fc = ua >= 32768; end
            10: begin r = ua / 2;                         fc = ua % 2; end
            11: begin r = ((ua * 2) + c) & 16'hFFFF;      fc = ua >= 32768; end
            default: begin r = (ua / 2) + c * 32768;      fc = ua % 2; end
        endcase
        case (o)
            0, 1, 2, 3: nar = {fc, r == 0, r >= 32768, fv};
            4, 5, 6, 7, 8: begin nar[2] = (r == 0); nar[1] = (r >= 32768); end
            9, 10, 11, 12: begin nar[3] = fc; nar[2] = (r == 0); end
            13: ncp = {fc, r == 0, r >= 32768, fv};
            14: begin ncp[2] = (r == 0); ncp[1] = (r >= 32768); end
            default: ;
        endcase
    endtask

    task automatic do_op(input int o, input int x, input int y);
        int r;
        logic [3:0] nar, ncp;
        string tg;
        @(negedge clk);
        op = o[3:0]; a = x[15:0]; b = y[15:0];
        tg = tag_of(o);
        model(o, x & 16'hFFFF, y & 16'hFFFF, r, nar, ncp);
        #5;
        check(tg, $sformatf("op%0d result", o), int'(result), r);
        @(posedge clk);
        m_ar = nar;
        m_cp = ncp;
        #1;
        // arithmetic-set untouched by CMP/TST is R7; compare-set holding is R8
        check((o == 13 || o == 14) ? "R7" : tg, $sformatf("op%0d arith_flags", o), int'(arith_flags), int'(m_ar));
        check((o == 13 || o == 14) ? "R7" : "R8", $sformatf("op%0d cmp_flags", o), int'(cmp_flags), int'(m_cp));
    endtask

    initial begin
        #1500000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset arith_flags", int'(arith_flags), 0);
        check("R1", "reset cmp_flags", int'(cmp_flags), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", "idle after reset arith", int'(arith_flags), 0);

        // R2 signed overflow and carry boundaries
        do_op(0, 16'h7FFF, 16'h0001);
        do_op(0, 16'hFFFF, 16'h0001);
        do_op(0, 16'h8000, 16'h8000);
        do_op(2, 16'h0000, 16'h0001);
        do_op(2, 16'h8000, 16'h0001);
        do_op(2, 16'h1234, 16'h1234);
        // R3 32-bit chains: 0x0001FFFF + 0x00000001, then 0x00010000 - 0x00000001
        do_op(0, 16'hFFFF, 16'h0001);
        do_op(1, 16'h0001, 16'h0000);
        do_op(2, 16'h0000, 16'h0001);
        do_op(3, 16'h0001, 16'h0000);
        // R4 logic keeps C,V (set C and V first)
        do_op(0, 16'h8000, 16'h8000);
        do_op(4, 16'hF0F0, 16'h0F0F);
        do_op(5, 16'h8000, 16'h0001);
        do_op(6, 16'hAAAA, 16'hAAAA);
        do_op(7, 16'h0000, 16'h0000);
        do_op(8, 16'h1234, 16'h0000);
        // R5 shifts
        do_op(9, 16'h8001, 0);
        do_op(10, 16'h0001, 0);
        do_op(10, 16'h0002, 0);
        // R6 rotate a bit out through carry and back in
        do_op(11, 16'h8000, 0);
        do_op(11, 16'h0000, 0);
        do_op(12, 16'h0001, 0);
        do_op(12, 16'h0000, 0);
        // R7 compare then arithmetic, compare result must persist (R8)
        do_op(13, 16'h0003, 16'h0005);
        do_op(0, 16'h0001, 16'h0001);
        do_op(14, 16'h00F0, 16'h0F00);
        do_op(14, 16'h8000, 16'hFFFF);
        do_op(13, 16'h8000, 16'h0001);
        // R9 address forming keeps flags
        do_op(15, 16'hFFFF, 16'h0002);

        for (int i = 0; i < 3000; i++) begin
            int ro, ra, rb;
            ro = $urandom_range(0, 15);
            ra = (i % 7 == 0) ? 16'h8000 : int'($urandom_range(0, 65535));
            rb = (i % 11 == 0) ? 16'hFFFF : int'($urandom_range(0, 65535));
            do_op(ro, ra, rb);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule